// File: doc/BRIEF.md
# Byte-Stepped I2C Master Controller

This block is a single-master I2C engine that software steers one byte at a time through three 8-bit registers on a simple write-strobe register port. Software writes the target address into the data register. It then writes a master mode together with the start bit and the output-enable bit into the status register. The engine issues a START and shifts the address out. After every byte, including its ninth (acknowledge) clock, the engine raises a pending flag, optionally raises an interrupt, and parks with SCL held low. Software services the byte: it reads received data or the acknowledge result, loads the next byte, and clears the pending flag to release the bus.

A STOP or a repeated START is requested by writing the status register while the bus is busy. The request takes effect when software next clears the pending flag. SCL and SDA are open-drain: the block pulls a line low by asserting its output enable and releases it otherwise. The SDA level is read back on a separate input. Clock stretching, slave operation and arbitration are not handled.

Register map, by `reg_addr`:
- 0 is control: bit 7 enables acknowledge generation, bit 6 selects the large prescaler, bit 5 enables the interrupt, bit 4 is the pending flag, bits 3:0 hold the divisor.
- 1 is status: bits 7:6 hold the mode, bit 5 is start/stop on write and busy on read, bit 4 enables the serial output, bit 0 is the acknowledge result.
- 2 is data.

Top module: `i2c_byte_master`

## Requirements
- R1: One SCL period, measured rising edge to rising edge within a byte, lasts P*(D+1) clock cycles. D is control bits 3:0. P is 16 when control bit 6 is 0 and 512 when it is 1.
- R2: Writing status with bits 7:6 = 11 or 10, bit 5 = 1 and bit 4 = 1 while idle does three things. It drives SDA low while SCL is high (START). It then clocks out the data register MSB first as the address byte. Status bit 5 reads 1 (busy) from then until the STOP completes.
- R3: Control bit 4 (pending) sets at the end of each byte's ninth clock. While it is set, SCL stays low. Writing 0 to it releases the next step, and writing 1 to it leaves it unchanged.
- R4: The `irq` output is 1 exactly when control bit 5 and control bit 4 are both 1.
- R5: After a transmitted byte, status bit 0 holds the SDA level sampled on the ninth clock: 1 = not acknowledged, 0 = acknowledged.
- R6: With mode 10, each byte after the address is sampled MSB first into the data register (address 2), readable once pending sets. On its ninth clock SDA is driven low when control bit 7 is 1 and released when it is 0.
- R7: Writing status with bit 5 = 0 while busy, then clearing pending, produces SDA rising while SCL is high (STOP). Afterwards busy reads 0 and pending stays 0.
- R8: Writing status with bit 5 = 1 and a master mode while busy, then clearing pending, produces a new START without a STOP. The data register is sent as the address, and the new mode governs the following bytes.
- R9: A start write with bit 4 = 0 or with mode 00 or 01, and a stop write while idle, are ignored: the bus stays released and busy stays 0.
- R10: Except during START and STOP conditions, SDA changes only while SCL is low.
- R11: After reset all three registers read 0 and both lines are released. Status reads back {mode, busy, output enable, 000, acknowledge result}, and the data register reads back what was written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 status, 2 data) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The bench covers the following corner cases and what a wrong design would do in each:
- Both prescaler settings and several divisors. A miscounted divider would show a wrong edge-to-edge SCL period.
- A slave that refuses the byte next to one that accepts it. A design sampling the acknowledge at the wrong clock would report the wrong status bit 0.
- A two-byte read that ends with acknowledge generation turned off. A design with the ninth-bit drive inverted would make the bench slave keep driving, which corrupts the STOP.
- A repeated START. A design that emitted a STOP there, or kept the old mode, would show an extra stop or a wrong received byte.
- Start and stop writes that must be ignored. These show up as a busy flag or a START counted on the bus when none was due.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 4;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam logic [1:0] MODE_TX = 2'b11;
  localparam logic [1:0] MODE_RX = 2'b10;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_BLO, ST_BHI, ST_HOLD,
    ST_RSA, ST_RSB, ST_SPA, ST_SPB, ST_SPC
  } eng_state_t;

  // half an SCL period is (prescaler/2) * (div+1) cycles
  function automatic int unsigned half_pre(input logic big, input int unsigned lo,
                                           input int unsigned hi);
    return big ? hi / 2 : lo / 2;
  endfunction

  function automatic logic is_master(input logic [1:0] mode);
    return mode[1];
  endfunction
endpackage

// File: rtl/i2c_bm_tick.sv
module i2c_bm_tick
  import i2c_bm_pkg::*;
#(
  parameter int unsigned PRE_LO = 16,
  parameter int unsigned PRE_HI = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_sel,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CW = $clog2(PRE_HI / 2 + 1);
  localparam logic [CW-1:0] LIM_LO = CW'(half_pre(1'b0, PRE_LO, PRE_HI) - 1);
  localparam logic [CW-1:0] LIM_HI = CW'(half_pre(1'b1, PRE_LO, PRE_HI) - 1);

  logic [CW-1:0]    pcnt;
  logic [DIV_W-1:0] dcnt;
  logic             pwrap;

  assign pwrap = (pcnt == (pre_sel ? LIM_HI : LIM_LO));
  assign tick  = run && pwrap && (dcnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (!run) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (pwrap) begin
      pcnt <= '0;
      dcnt <= tick ? '0 : dcnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_bm_regs.sv
module i2c_bm_regs
  import i2c_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              byte_done,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              nack_upd,
  input  logic              nack_val,
  input  logic              busy,
  output logic              ack_en,
  output logic              pre_sel,
  output logic              pend,
  output logic [DIV_W-1:0]  div,
  output logic              tx_mode,
  output logic [BYTE_W-1:0] data_q,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              irq
);
  logic       irq_en, out_en, nack;
  logic [1:0] mode;
  logic       wr_ctrl, wr_stat, wr_data;
  wire        unused_stat_bits = ^wdata[3:0];

  assign wr_ctrl = we && (addr == A_CTRL);
  assign wr_stat = we && (addr == A_STAT);
  assign wr_data = we && (addr == A_DATA);

  assign cmd_start = wr_stat && wdata[5] && wdata[4] && is_master(wdata[7:6]);
  assign cmd_stop  = wr_stat && !wdata[5];
  assign tx_mode   = (mode == MODE_TX);
  assign irq       = pend && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_en  <= 1'b0;
      pre_sel <= 1'b0;
      irq_en  <= 1'b0;
      div     <= '0;
      pend    <= 1'b0;
      mode    <= 2'b00;
      out_en  <= 1'b0;
      nack    <= 1'b0;
      data_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ack_en  <= wdata[7];
        pre_sel <= wdata[6];
        irq_en  <= wdata[5];
        div     <= wdata[DIV_W-1:0];
      end
      if (byte_done)                pend <= 1'b1;
      else if (wr_ctrl && !wdata[4]) pend <= 1'b0;
      if (wr_stat) begin
        mode   <= wdata[7:6];
        out_en <= wdata[4];
      end
      if (rx_load)      data_q <= rx_byte;
      else if (wr_data) data_q <= wdata;
      if (nack_upd) nack <= nack_val;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {ack_en, pre_sel, irq_en, pend, div};
      A_STAT:  rdata = {mode, busy, out_en, 3'b000, nack};
      A_DATA:  rdata = data_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
  import i2c_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              pend,
  input  logic              tx_mode,
  input  logic              ack_en,
  input  logic [BYTE_W-1:0] data_q,
  input  logic              sda_in,
  output logic              run,
  output logic              busy,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              byte_done,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              nack_upd,
  output logic              nack_val,
  output logic              cond_phase
);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(BYTE_W);

  eng_state_t        st;
  logic [BIT_W-1:0]  bidx;
  logic [BYTE_W-1:0] shreg;
  logic              first, stop_req, rs_req;
  logic              tx_now, last_hi;

  assign tx_now  = first || tx_mode;
  assign last_hi = (st == ST_BHI) && tick && (bidx == ACK_SLOT);

  assign byte_done  = last_hi;
  assign rx_load    = last_hi && !tx_now;
  assign nack_upd   = last_hi && tx_now;
  assign nack_val   = sda_in;
  assign rx_byte    = shreg;
  assign busy       = (st != ST_IDLE);
  assign run        = (st != ST_IDLE) && (st != ST_HOLD);
  assign cond_phase = (st == ST_START) || (st == ST_SPC);

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      ST_START: sda_oe = 1'b1;
      ST_BLO, ST_BHI: begin
        scl_oe = (st == ST_BLO);
        if (bidx == ACK_SLOT) sda_oe = !tx_now && ack_en;
        else                  sda_oe = tx_now && !shreg[BYTE_W-1];
      end
      ST_HOLD, ST_RSA: scl_oe = 1'b1;
      ST_SPA: begin
        scl_oe = 1'b1;
        sda_oe = 1'b1;
      end
      ST_SPB:  sda_oe = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bidx     <= '0;
      shreg    <= '0;
      first    <= 1'b0;
      stop_req <= 1'b0;
      rs_req   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (cmd_start) begin
          st    <= ST_START;
          first <= 1'b1;
        end
        ST_START: if (tick) begin
          st    <= ST_BLO;
          bidx  <= '0;
          shreg <= data_q;
        end
        ST_BLO: if (tick) st <= ST_BHI;
        ST_BHI: if (tick) begin
          if (bidx == ACK_SLOT) begin
            st    <= ST_HOLD;
            first <= 1'b0;
          end else begin
            st    <= ST_BLO;
            bidx  <= bidx + 1'b1;
            shreg <= {shreg[BYTE_W-2:0], sda_in};
          end
        end
        ST_HOLD: if (!pend) begin
          stop_req <= 1'b0;
          rs_req   <= 1'b0;
          if (stop_req)    st <= ST_SPA;
          else if (rs_req) st <= ST_RSA;
          else begin
            st    <= ST_BLO;
            bidx  <= '0;
            shreg <= data_q;
          end
        end
        ST_RSA: if (tick) st <= ST_RSB;
        ST_RSB: if (tick) begin
          st    <= ST_START;
          first <= 1'b1;
        end
        ST_SPA: if (tick) st <= ST_SPB;
        ST_SPB: if (tick) st <= ST_SPC;
        ST_SPC: if (tick) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (st != ST_IDLE) begin
        if (cmd_stop)  stop_req <= 1'b1;
        if (cmd_start) rs_req   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int unsigned PRE_LO = 16,
  parameter int unsigned PRE_HI = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in
);
  logic              tick, run, busy, byte_done, rx_load, nack_upd, nack_val;
  logic              cond_phase, ack_en, pre_sel, pend, tx_mode, cmd_start, cmd_stop;
  logic [DIV_W-1:0]  div;
  logic [BYTE_W-1:0] data_q, rx_byte;

  i2c_bm_tick #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_sel(pre_sel), .div(div), .tick(tick)
  );

  i2c_bm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .byte_done(byte_done), .rx_load(rx_load), .rx_byte(rx_byte),
    .nack_upd(nack_upd), .nack_val(nack_val), .busy(busy), .ack_en(ack_en),
    .pre_sel(pre_sel), .pend(pend), .div(div), .tx_mode(tx_mode), .data_q(data_q),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .irq(irq)
  );

  i2c_bm_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .pend(pend), .tx_mode(tx_mode), .ack_en(ack_en), .data_q(data_q), .sda_in(sda_in),
    .run(run), .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe), .byte_done(byte_done),
    .rx_load(rx_load), .rx_byte(rx_byte), .nack_upd(nack_upd), .nack_val(nack_val),
    .cond_phase(cond_phase)
  );
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic irq,
  input logic pend,
  input logic busy,
  input logic byte_done,
  input logic cond_phase
);
  p_hold_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> scl_oe);

  p_pend_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(byte_done));

  p_irq_needs_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

  p_start_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sda_oe && !scl_oe));

  p_stop_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!sda_oe && !scl_oe && !pend));

  p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && !cond_phase) |-> $stable(sda_oe));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
  .pend(pend), .busy(busy), .byte_done(byte_done), .cond_phase(cond_phase)
);

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  bit         sl_drive = 1'b0;
  wire        sda_line = !(sda_oe || sl_drive);

  always #2 clk = ~clk;

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // bus slave model and SCL period monitor
  int  cyc = 0, last_rise = 0, period = 0;
  int  bc = -1, bi = 0, nrx = 0, n_start = 0, n_stop = 0;
  bit  rd = 1'b0, rd_stop = 1'b0, ack_seen = 1'b0, sl_nack = 1'b0;
  bit  prev_scl = 1'b1, prev_sda = 1'b1;
  logic [7:0] sh = 8'h00;
  logic [7:0] got [0:31];
  logic [7:0] sl_rdata [0:3];

  always @(negedge clk) begin
    bit scl_l, sda_l;
    scl_l = !scl_oe;
    sda_l = sda_line;
    cyc++;
    if (scl_l && !prev_scl) begin
      period = cyc - last_rise;
      last_rise = cyc;
      if (bc >= 0 && bc < 8) sh = {sh[6:0], sda_l};
      else if (bc == 8) ack_seen = sda_l;
    end
    if (!scl_l && prev_scl) begin
      bc = bc + 1;
      if (bc == 9) begin
        if (rd && bi > 0 && ack_seen) rd_stop = 1'b1;
        bi++;
        bc = 0;
      end
      if (bc == 8) begin
        if (bi == 0 || !rd) begin
          got[nrx % 32] = sh;
          if (bi == 0) rd = sh[0];
          nrx++;
          sl_drive = !sl_nack;
        end else sl_drive = 1'b0;
      end else
        sl_drive = (rd && !rd_stop && bi > 0) ? !sl_rdata[(bi - 1) % 4][7 - bc] : 1'b0;
    end
    if (scl_l && prev_scl && prev_sda && !sda_l) begin
      n_start++;
      bc = -1; bi = 0; rd = 1'b0; rd_stop = 1'b0; sl_drive = 1'b0;
    end
    if (scl_l && prev_scl && !prev_sda && sda_l) begin
      n_stop++;
      bc = -1; sl_drive = 1'b0;
    end
    prev_scl = scl_l;
    prev_sda = sda_l;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rdr(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_pend();
    logic [7:0] r;
    r = 8'h00;
    while (!r[4]) rdr(2'd0, r);
  endtask

  task automatic wait_idle();
    logic [7:0] r;
    r = 8'hFF;
    while (r[5]) rdr(2'd1, r);
  endtask

  // {addr7, data8, slave_nack, div4}
  localparam logic [19:0] VEC [0:3] = '{
    {7'h50, 8'hA5, 1'b0, 4'd0},
    {7'h2B, 8'h3C, 1'b1, 4'd2},
    {7'h7F, 8'h00, 1'b0, 4'd5},
    {7'h01, 8'hFF, 1'b1, 4'd1}
  };

  initial begin
    logic [7:0] r;
    int base_rx, st0, sp0;
    sl_rdata[0] = 8'h96; sl_rdata[1] = 8'h3B; sl_rdata[2] = 8'h00; sl_rdata[3] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rdr(2'd0, r); chk("R11 ctrl reset", r, 0);
    rdr(2'd1, r); chk("R11 stat reset", r, 0);
    rdr(2'd2, r); chk("R11 data reset", r, 0);
    chk("R11 lines released", {scl_oe, sda_oe, irq}, 0);
    // R3 writing 1 to pending does not set it
    wr(2'd0, 8'h10); rdr(2'd0, r); chk("R3 pend write-1 ignored", r, 8'h00);
    wr(2'd2, 8'h5A); rdr(2'd2, r); chk("R11 data readback", r, 8'h5A);

    // vector table: address + one data byte, then stop
    for (int i = 0; i < 4; i++) begin
      logic [6:0] a; logic [7:0] d; logic nk; logic [3:0] dv;
      {a, d, nk, dv} = VEC[i];
      sl_nack = nk; base_rx = nrx; st0 = n_start; sp0 = n_stop;
      wr(2'd0, {4'hA, dv});
      wr(2'd2, {a, 1'b0});
      wr(2'd1, 8'hF0);
      rdr(2'd1, r); chk("R2 busy after start", r[5], 1);
      wait_pend();
      chk("R1 scl period pre16", period, 16 * (dv + 1));
      rdr(2'd1, r); chk("R5 address ack bit", r[0], nk);
      chk("R11 stat layout", r[7:4], 4'hF);
      wr(2'd2, d);
      wr(2'd0, {4'hA, dv});
      wait_pend();
      wr(2'd1, 8'hD0);
      wr(2'd0, {4'hA, dv});
      wait_idle();
      chk("R2 address byte on bus", got[base_rx % 32], {a, 1'b0});
      chk("R2 data byte on bus", got[(base_rx + 1) % 32], d);
      chk("R2 one start", n_start, st0 + 1);
      chk("R7 one stop", n_stop, sp0 + 1);
      rdr(2'd0, r); chk("R7 pend clear after stop", r[4], 0);
    end

    // receive: address, two bytes (ack then nack)
    sl_nack = 1'b0; base_rx = nrx; sp0 = n_stop;
    wr(2'd0, 8'hA1);
    wr(2'd2, {7'h48, 1'b1});
    wr(2'd1, 8'hB0);
    wait_pend();
    rdr(2'd1, r); chk("R5 read address acked", r[0], 0);
    chk("R2 read address on bus", got[base_rx % 32], {7'h48, 1'b1});
    wr(2'd0, 8'hA1);
    wait_pend();
    rdr(2'd2, r); chk("R6 first byte received", r, 8'h96);
    chk("R6 master ack driven", ack_seen, 0);
    wr(2'd0, 8'h21);
    wait_pend();
    rdr(2'd2, r); chk("R6 second byte received", r, 8'h3B);
    chk("R6 master nack released", ack_seen, 1);
    chk("R4 irq with pend and enable", irq, 1);
    wr(2'd0, 8'h11);
    @(negedge clk);
    chk("R4 irq off when disabled", irq, 0);
    rdr(2'd0, r); chk("R3 pend kept by writing 1", r[4], 1);
    repeat (100) @(negedge clk);
    chk("R3 scl held low while pending", scl_oe, 1);
    wr(2'd1, 8'h90);
    wr(2'd0, 8'h01);
    wait_idle();
    chk("R7 stop after read", n_stop, sp0 + 1);

    // repeated start: write pointer, then switch to read
    sl_nack = 1'b0; sl_rdata[0] = 8'hC3;
    wr(2'd0, 8'hA1);
    wr(2'd2, {7'h33, 1'b0});
    wr(2'd1, 8'hF0);
    wait_pend();
    wr(2'd2, 8'h11);
    wr(2'd0, 8'hA1);
    wait_pend();
    st0 = n_start; sp0 = n_stop; base_rx = nrx;
    wr(2'd2, {7'h33, 1'b1});
    wr(2'd1, 8'hB0);
    wr(2'd0, 8'h21);
    wait_pend();
    chk("R8 second start seen", n_start, st0 + 1);
    chk("R8 no stop between", n_stop, sp0);
    chk("R8 new address sent", got[base_rx % 32], {7'h33, 1'b1});
    rdr(2'd1, r); chk("R8 busy and new mode", {r[7:6], r[5]}, 3'b101);
    wr(2'd0, 8'h21);
    wait_pend();
    rdr(2'd2, r); chk("R8 byte read after restart", r, 8'hC3);
    wr(2'd1, 8'h90);
    wr(2'd0, 8'h01);
    wait_idle();
    chk("R8 final stop", n_stop, sp0 + 1);

    // ignored commands
    st0 = n_start; sp0 = n_stop;
    wr(2'd1, 8'hE0);
    repeat (200) @(negedge clk);
    rdr(2'd1, r); chk("R9 start without output enable", r[5], 0);
    wr(2'd1, 8'h30);
    repeat (200) @(negedge clk);
    rdr(2'd1, r); chk("R9 start in mode 00", r[5], 0);
    wr(2'd1, 8'h70);
    repeat (200) @(negedge clk);
    rdr(2'd1, r); chk("R9 start in mode 01", r[5], 0);
    wr(2'd1, 8'hD0);
    repeat (200) @(negedge clk);
    chk("R9 lines idle", {scl_oe, sda_oe}, 0);
    chk("R9 no start on bus", n_start, st0);
    chk("R9 no stop on bus", n_stop, sp0);

    // large prescaler
    wr(2'd0, 8'hC0);
    wr(2'd2, {7'h22, 1'b0});
    wr(2'd1, 8'hF0);
    wait_pend();
    chk("R1 scl period pre512", period, 512);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'hC0);
    wait_idle();
    rdr(2'd1, r); chk("R7 busy cleared", r[5], 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule